// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial input line into parallel characters. The input is sampled on a 16x oversampling strobe, `os_tick`, that comes from a baud divider outside the block. A falling edge on the idle line starts a frame. The start bit is then re-checked at the middle of the bit. Character bits, an optional parity bit and one or two stop bits follow, and each is sampled at the middle of its bit period. The finished character is moved into a one-entry holding buffer, and a one-cycle interrupt pulse is raised.

Several frame options are set through static configuration inputs:
- the character length (7, 8 or 9 bits);
- parity (none, even or odd);
- the number of stop bits;
- the bit order;
- inversion of the payload bits;
- inversion of the whole input pin.

Three error flags report overrun, framing and parity faults, and a sum flag is the OR of the three. A single read strobe empties the buffer and clears every flag. A ready-to-send output, active low, tells the far end when the buffer can take a character.

Top module: `serial_rx_unit`

## Requirements
- R1: While `rx_en` is low the receiver stays idle: frames on the line are ignored, no interrupt is raised and `rx_full` does not change. Reception starts only with `rx_en` high and a detected start bit.
- R2: A frame that completes while the buffer is empty loads `rx_data`, sets `rx_full` and gives exactly one `rx_irq` pulse, one clock long.
- R3: `cfg_len` selects the character length: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 give 9 bits. Bits above the length read as 0. With `cfg_msb_first` at 0 the lowest character bit is received first. With it at 1 the highest character bit is received first.
- R4: An overrun is declared when `rx_full` is still set at the end of the bit that comes before the last stop bit of the next frame. `err_overrun` is then set, that frame is not loaded into the buffer, and no `rx_irq` is raised for it.
- R5: `err_frame` is set when any of the configured stop bits (`cfg_two_stop`: 0 means one stop bit, 1 means two) is sampled low.
- R6: With `cfg_par_en` high, `err_parity` is set when the number of ones over the character and parity bits is odd in even mode (`cfg_par_odd` = 0), or even in odd mode (`cfg_par_odd` = 1).
- R7: `err_sum` is high exactly when at least one of `err_overrun`, `err_frame` and `err_parity` is high.
- R8: `cfg_data_inv` inverts only the character and parity bits as they are received. `cfg_line_inv` inverts the pin before any other processing, so the idle level and the start and stop bits are inverted as well.
- R9: A frame starts on a high-to-low change of the idle line. The start bit is re-sampled on the 8th oversampling tick, and if the line is high there the receiver returns to idle with no effect. Every later bit is sampled on its 8th tick.
- R10: `rts_n` is low when `rx_en` is high and the buffer is empty. Otherwise it is high.
- R11: A one-cycle `rd_strobe` clears `rx_full`, `err_overrun`, `err_frame`, `err_parity` and `err_sum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | 16x oversampling strobe, high for one clock |
| rx_en | input | 1 | Receive enable |
| rxd_pin | input | 1 | Serial input pin |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_msb_first | input | 1 | Highest character bit is received first |
| cfg_data_inv | input | 1 | Invert character and parity bits |
| cfg_line_inv | input | 1 | Invert the whole input pin |
| rd_strobe | input | 1 | Read of the buffer: empties it and clears the flags |
| rx_data | output | 9 | Buffered character |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| err_overrun | output | 1 | Overrun error flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| rts_n | output | 1 | Ready to receive, active low |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, a two-stage input synchronizer and a 9-bit character ceiling. It drives `os_tick` on every second clock, so each bit lasts 32 clocks. That spacing puts the mid-bit sample clear of the synchronizer delay. It also lets a 4-tick low glitch show the false-start path. The defaults cover all three character lengths, both bit orders, both parity senses, one and two stop bits, and every combination of the two inversions. They also reach the overrun point, in a frame that arrives while the buffer is still full.

// File: rtl/rxu_pkg.sv
// Package rxu_pkg: types and helpers shared by the receiver modules.
// Assumes a character of at most CHAR_MAX bits.
package rxu_pkg;

    parameter int unsigned CHAR_MAX = 9;

    // Static frame options that the datapath reads.
    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
        logic       msb_first;
        logic       data_inv;
    } rxu_cfg_t;

    // Converts the length code into a bit count (codes 2 and 3 both mean 9).
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd7;
            2'd1:    return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/rxu_line_sampler.sv
// Module rxu_line_sampler: applies the pin polarity option, synchronizes the
// input and flags a high-to-low change seen on an oversampling tick.
// Assumes rxd_pin is asynchronous to clk and that os_tick lasts one clock.
module rxu_line_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rxd_pin,
    input  logic line_inv,
    output logic line_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_hi_q;

    // Synchronizer chain. The polarity is applied first, so the logical idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_pin ^ line_inv};
    end

    assign line_o = sync_q[SYNC_STAGES-1];

    // Keeps the line level seen at the previous tick, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)       prev_hi_q <= 1'b1;
        else if (os_tick) prev_hi_q <= line_o;
    end

    assign fall_o = os_tick & prev_hi_q & ~line_o;

endmodule

// File: rtl/rxu_frame_fsm.sv
// Module rxu_frame_fsm: the frame sequencer. It validates the start bit,
// samples payload and stop bits at mid-bit, accumulates parity, and marks a
// frame as dropped when the buffer is still full at the bit before the last stop bit.
// Assumes the cfg fields stay constant while a frame is in progress.
module rxu_frame_fsm
    import rxu_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_en,
    input  rxu_cfg_t            cfg,
    input  logic                line_i,
    input  logic                fall_i,
    input  logic                buf_full_i,
    output logic                done_o,
    output logic                drop_o,
    output logic                ovr_hit_o,
    output logic [CHAR_MAX-1:0] char_o,
    output logic                fe_o,
    output logic                pe_o
);

    localparam int unsigned    CW   = $clog2(OSR);
    localparam logic [CW-1:0]  MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0]  LAST = CW'(OSR - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_PAYLOAD, ST_STOP} rx_state_e;

    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [3:0]          bit_idx;
    logic                stop_idx;
    logic                par_acc;
    logic                ovr_mark;
    logic                fe_acc;
    logic [CHAR_MAX-1:0] shreg;
    logic [3:0]          nchar, npay, pos;
    logic                bit_v, mid_hit, end_hit;

    // Derives the bit counts, the target bit position and the sample strobes.
    always_comb begin
        nchar   = char_bits(cfg.len);
        npay    = nchar + {3'b000, cfg.par_en};
        pos     = cfg.msb_first ? (nchar - 4'd1 - bit_idx) : bit_idx;
        bit_v   = line_i ^ cfg.data_inv;
        mid_hit = os_tick && (cnt == MID);
        end_hit = os_tick && (cnt == LAST);
    end

    // Frame state machine. It advances on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            stop_idx  <= 1'b0;
            par_acc   <= 1'b0;
            ovr_mark  <= 1'b0;
            fe_acc    <= 1'b0;
            shreg     <= '0;
            done_o    <= 1'b0;
            drop_o    <= 1'b0;
            ovr_hit_o <= 1'b0;
            fe_o      <= 1'b0;
            pe_o      <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            ovr_hit_o <= 1'b0;
            if (!rx_en) begin
                state <= ST_IDLE;
            end else if (os_tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (fall_i) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        cnt <= cnt + 1'b1;
                        if (mid_hit && line_i) begin
                            state <= ST_IDLE;
                        end else if (end_hit) begin
                            state    <= ST_PAYLOAD;
                            cnt      <= '0;
                            bit_idx  <= '0;
                            stop_idx <= 1'b0;
                            par_acc  <= 1'b0;
                            ovr_mark <= 1'b0;
                            fe_acc   <= 1'b0;
                            shreg    <= '0;
                        end
                    end
                    ST_PAYLOAD: begin
                        cnt <= cnt + 1'b1;
                        if (mid_hit) begin
                            par_acc <= par_acc ^ bit_v;
                            if (bit_idx < nchar) shreg[pos] <= bit_v;
                        end
                        if (end_hit) begin
                            cnt <= '0;
                            if (bit_idx == npay - 4'd1) begin
                                state <= ST_STOP;
                                if (!cfg.two_stop) begin
                                    ovr_mark  <= buf_full_i;
                                    ovr_hit_o <= buf_full_i;
                                end
                            end else begin
                                bit_idx <= bit_idx + 4'd1;
                            end
                        end
                    end
                    ST_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (mid_hit && (stop_idx == cfg.two_stop)) begin
                            done_o <= 1'b1;
                            drop_o <= ovr_mark;
                            fe_o   <= fe_acc | ~line_i;
                            pe_o   <= cfg.par_en && (par_acc != cfg.par_odd);
                            state  <= ST_IDLE;
                        end else if (mid_hit) begin
                            fe_acc <= fe_acc | ~line_i;
                        end
                        if (end_hit) begin
                            cnt       <= '0;
                            stop_idx  <= 1'b1;
                            ovr_mark  <= buf_full_i;
                            ovr_hit_o <= buf_full_i;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign char_o = shreg;

    AST_DISABLE_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == ST_IDLE); // R1

    AST_FALSE_START_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && state == ST_START && mid_hit && line_i) |=> state == ST_IDLE); // R9

    AST_DONE_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state) == ST_STOP); // R5

endmodule

// File: rtl/rxu_hold_buffer.sv
// Module rxu_hold_buffer: the one-entry receive buffer with its error flags,
// the interrupt pulse and the ready-to-send output.
// Assumes done_i, drop_i and ovr_hit_i are single-cycle pulses from the sequencer.
module rxu_hold_buffer
    import rxu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                rd_i,
    input  logic                done_i,
    input  logic                drop_i,
    input  logic                ovr_hit_i,
    input  logic [CHAR_MAX-1:0] char_i,
    input  logic                fe_i,
    input  logic                pe_i,
    output logic [CHAR_MAX-1:0] data_o,
    output logic                full_o,
    output logic                irq_o,
    output logic                ovr_o,
    output logic                fe_o,
    output logic                pe_o,
    output logic                sum_o,
    output logic                rts_n_o
);

    logic [CHAR_MAX-1:0] n_data;
    logic                n_full, n_ovr, n_fe, n_pe, n_irq;

    // Next-state logic. A read clears first, and a new event then sets.
    always_comb begin
        n_data = data_o;
        n_full = full_o;
        n_ovr  = ovr_o;
        n_fe   = fe_o;
        n_pe   = pe_o;
        n_irq  = 1'b0;
        if (rd_i) begin
            n_full = 1'b0;
            n_ovr  = 1'b0;
            n_fe   = 1'b0;
            n_pe   = 1'b0;
        end
        if (ovr_hit_i) n_ovr = 1'b1;
        if (done_i && !drop_i) begin
            n_data = char_i;
            n_full = 1'b1;
            n_fe   = fe_i;
            n_pe   = pe_i;
            n_irq  = 1'b1;
        end
    end

    // Buffer and flag registers. The sum flag is registered on its own.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            full_o <= 1'b0;
            ovr_o  <= 1'b0;
            fe_o   <= 1'b0;
            pe_o   <= 1'b0;
            sum_o  <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            data_o <= n_data;
            full_o <= n_full;
            ovr_o  <= n_ovr;
            fe_o   <= n_fe;
            pe_o   <= n_pe;
            sum_o  <= n_ovr | n_fe | n_pe;
            irq_o  <= n_irq;
        end
    end

    assign rts_n_o = ~(rx_en & ~full_o);

    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> full_o); // R2

    AST_NO_IRQ_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && drop_i) |=> !irq_o); // R4

    AST_SUM_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o == (ovr_o | fe_o | pe_o)); // R7

    AST_RTS_HIGH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> rts_n_o); // R10

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i && !ovr_hit_i) |=> (!full_o && !sum_o)); // R11

endmodule

// File: rtl/serial_rx_unit.sv
// Module serial_rx_unit: top of the oversampled asynchronous receiver.
// It connects the line sampler, the frame sequencer and the hold buffer.
// Assumes os_tick runs at OSR times the bit rate, with each strobe one clock long.
module serial_rx_unit
    import rxu_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_en,
    input  logic       rxd_pin,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       cfg_msb_first,
    input  logic       cfg_data_inv,
    input  logic       cfg_line_inv,
    input  logic       rd_strobe,
    output logic [8:0] rx_data,
    output logic       rx_full,
    output logic       rx_irq,
    output logic       err_overrun,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_sum,
    output logic       rts_n
);

    rxu_cfg_t            cfg;
    logic                line, fall;
    logic                done, drop, ovr_hit, fe, pe;
    logic [CHAR_MAX-1:0] chr;

    // Gathers the static options into one struct.
    always_comb begin
        cfg.len       = cfg_len;
        cfg.par_en    = cfg_par_en;
        cfg.par_odd   = cfg_par_odd;
        cfg.two_stop  = cfg_two_stop;
        cfg.msb_first = cfg_msb_first;
        cfg.data_inv  = cfg_data_inv;
    end

    rxu_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .rxd_pin  (rxd_pin),
        .line_inv (cfg_line_inv),
        .line_o   (line),
        .fall_o   (fall)
    );

    rxu_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .rx_en      (rx_en),
        .cfg        (cfg),
        .line_i     (line),
        .fall_i     (fall),
        .buf_full_i (rx_full),
        .done_o     (done),
        .drop_o     (drop),
        .ovr_hit_o  (ovr_hit),
        .char_o     (chr),
        .fe_o       (fe),
        .pe_o       (pe)
    );

    rxu_hold_buffer u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .rd_i      (rd_strobe),
        .done_i    (done),
        .drop_i    (drop),
        .ovr_hit_i (ovr_hit),
        .char_i    (chr),
        .fe_i      (fe),
        .pe_i      (pe),
        .data_o    (rx_data),
        .full_o    (rx_full),
        .irq_o     (rx_irq),
        .ovr_o     (err_overrun),
        .fe_o      (err_frame),
        .pe_o      (err_parity),
        .sum_o     (err_sum),
        .rts_n_o   (rts_n)
    );

endmodule

// File: tb/serial_rx_unit_tb_top.sv
// Bench for serial_rx_unit: a table-driven frame loop, followed by directed
// tests for reset, disable, false start and overrun.
module serial_rx_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxd_pin = 1'b1;
    logic [1:0] cfg_len = 2'd1;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cfg_msb_first = 1'b0, cfg_data_inv = 1'b0, cfg_line_inv = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, rx_irq, err_overrun, err_frame, err_parity, err_sum, rts_n;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;

    serial_rx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en), .rxd_pin(rxd_pin),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
        .cfg_data_inv(cfg_data_inv), .cfg_line_inv(cfg_line_inv), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq), .err_overrun(err_overrun),
        .err_frame(err_frame), .err_parity(err_parity), .err_sum(err_sum), .rts_n(rts_n)
    );

    initial forever #2 clk = ~clk;

    initial forever begin
        @(negedge clk);
        os_tick = ~os_tick;
    end

    always @(negedge clk) if (rx_irq) irq_cnt++;

    typedef struct packed {
        logic [1:0] len;
        logic       pen, podd, two, msb, dinv, linv, bpar, bstop;
        logic [8:0] chr;
        logic       epe, efe;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0}, // R2 8N1
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0}, // R3 7 bits, even
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1C3, 1'b0, 1'b0}, // R3 9 bits, MSB first
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0F0, 1'b0, 1'b0}, // R8 data inversion
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0}, // R8 line inversion
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'h081, 1'b1, 1'b0}, // R6 bad even parity
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h07E, 1'b0, 1'b1}, // R5 bad stop
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 9'h155, 1'b0, 1'b1}, // R5 second stop low
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h033, 1'b1, 1'b0}  // R6 bad odd parity
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic b);
        rxd_pin = b ^ cfg_line_inv;
        repeat (32) @(negedge clk);
    endtask

    task automatic idle_gap(input int nbits);
        rxd_pin = ~cfg_line_inv;
        repeat (32 * nbits) @(negedge clk);
    endtask

    // Builds the wire sequence from the frame rules in the requirements.
    task automatic send_frame(input logic bpar, input logic bstop, input logic [8:0] chr);
        int   n;
        logic par;
        n   = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd1) ? 8 : 9;
        par = 1'b0;
        for (int i = 0; i < n; i++) par = par ^ chr[i];
        if (cfg_par_odd) par = ~par;
        if (bpar) par = ~par;
        line_bit(1'b0);
        for (int i = 0; i < n; i++) line_bit(chr[cfg_msb_first ? (n - 1 - i) : i] ^ cfg_data_inv);
        if (cfg_par_en) line_bit(par ^ cfg_data_inv);
        line_bit(!(bstop && !cfg_two_stop));
        if (cfg_two_stop) line_bit(!bstop);
        rxd_pin = ~cfg_line_inv;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk("R2 reset rx_full", {31'b0, rx_full}, 0);
        chk("R7 reset err_sum", {31'b0, err_sum}, 0);
        chk("R10 rts_n while disabled", {31'b0, rts_n}, 1);

        // R1: a frame sent while disabled is ignored.
        base = irq_cnt;
        idle_gap(2);
        send_frame(1'b0, 1'b0, 9'h0AA);
        chk("R1 no irq while disabled", irq_cnt - base, 0);
        chk("R1 rx_full while disabled", {31'b0, rx_full}, 0);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R10 rts_n enabled and empty", {31'b0, rts_n}, 0);

        // Table of frames.
        for (int v = 0; v < NV; v++) begin
            cfg_len = VECS[v].len;       cfg_par_en = VECS[v].pen;
            cfg_par_odd = VECS[v].podd;  cfg_two_stop = VECS[v].two;
            cfg_msb_first = VECS[v].msb; cfg_data_inv = VECS[v].dinv;
            cfg_line_inv = VECS[v].linv;
            idle_gap(3);
            base = irq_cnt;
            send_frame(VECS[v].bpar, VECS[v].bstop, VECS[v].chr);
            chk($sformatf("R3 data vec%0d", v), {23'b0, rx_data}, {23'b0, VECS[v].chr});
            chk($sformatf("R2 one irq vec%0d", v), irq_cnt - base, 1);
            chk($sformatf("R2 full vec%0d", v), {31'b0, rx_full}, 1);
            chk($sformatf("R6 parity vec%0d", v), {31'b0, err_parity}, {31'b0, VECS[v].epe});
            chk($sformatf("R5 frame vec%0d", v), {31'b0, err_frame}, {31'b0, VECS[v].efe});
            chk($sformatf("R7 sum vec%0d", v), {31'b0, err_sum}, {31'b0, VECS[v].epe | VECS[v].efe});
            chk($sformatf("R10 rts_n full vec%0d", v), {31'b0, rts_n}, 1);
            do_read();
            chk($sformatf("R11 full cleared vec%0d", v), {31'b0, rx_full}, 0);
            chk($sformatf("R11 sum cleared vec%0d", v), {31'b0, err_sum}, 0);
        end

        // R9: a short low glitch is a false start.
        cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        cfg_msb_first = 1'b0; cfg_data_inv = 1'b0; cfg_line_inv = 1'b0;
        idle_gap(3);
        base = irq_cnt;
        rxd_pin = 1'b0;
        repeat (8) @(negedge clk);
        idle_gap(14);
        chk("R9 false start no irq", irq_cnt - base, 0);
        chk("R9 false start buffer empty", {31'b0, rx_full}, 0);
        send_frame(1'b0, 1'b0, 9'h0C9);
        chk("R9 frame after glitch", {23'b0, rx_data}, 32'h0C9);
        do_read();

        // R4: overrun on a second frame while the buffer is full.
        idle_gap(2);
        base = irq_cnt;
        send_frame(1'b0, 1'b0, 9'h011);
        idle_gap(2);
        send_frame(1'b0, 1'b0, 9'h0EE);
        chk("R4 overrun flag", {31'b0, err_overrun}, 1);
        chk("R4 single irq", irq_cnt - base, 1);
        chk("R7 sum on overrun", {31'b0, err_sum}, 1);
        chk("R4 still full", {31'b0, rx_full}, 1);
        do_read();
        chk("R11 overrun cleared", {31'b0, err_overrun}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule